// File: doc/BRIEF.md
# Multithreaded Round-Robin Thread Picker

This block decides, every clock cycle, which of the hardware thread contexts of a fine-grained multithreaded in-order core may issue. At most one thread is chosen per cycle. Threads are served in rotation, and the rotation passes over any thread that cannot make progress. A thread cannot make progress while it is blocked by a long-latency event, such as a cache miss or a divide. It also cannot make progress while it sleeps after a monitor-wait instruction.

Each context keeps two independent conditions: a stall flag and a sleep flag. The stall flag is raised and lowered by per-thread set and clear pulses. The sleep flag is raised by a monitor-arm request, which also captures the address to watch. A store-observation bus reports every store. When a store falls in the same 64-byte line as a sleeping thread's watched address, that thread wakes.

The grant is given both as a one-hot vector and as an encoded index, together with a valid flag. It is a combinational function of registered state, so an event seen at one clock edge affects the grant in the cycle that follows that edge.

Top module: `mt_thread_picker`

## Requirements
- R1: `grant_oh` has at most one bit set. `grant_valid` is 1 exactly when `grant_oh` is nonzero. When `grant_valid` is 1, `grant_id` is the index of the set bit.
- R2: Among eligible threads, the grant goes to the first eligible thread found when searching upward from the rotation pointer, wrapping after thread 3. With all threads eligible, the grants follow 0,1,2,3,0,...
- R3: A `stall_set[i]` pulse keeps thread i out of every grant from the next cycle on. A `stall_clr[i]` pulse makes it eligible again from the next cycle, unless it sleeps.
- R4: If `stall_set[i]` and `stall_clr[i]` are both high in the same cycle, thread i ends up stalled.
- R5: A `mwait_req[i]` pulse puts thread i to sleep and captures slice i of `mwait_addr` (bits [i*ADDR_W +: ADDR_W]). A sleeping thread is never granted.
- R6: A store (`st_valid`=1) wakes every sleeping thread whose watched address matches `st_addr` in bits [ADDR_W-1:6]. The thread is eligible from the next cycle. A store to any other line leaves the thread asleep.
- R7: A thread that is both stalled and sleeping stays ineligible until both its stall has been cleared and it has been woken, in either order.
- R8: When no thread is eligible, `grant_valid` is 0, `grant_oh` is 0, and the rotation pointer is held.
- R9: After reset, no thread is stalled or asleep and the rotation pointer is 0, so thread 0 is granted first.
- R10: If a thread's arm request and a store arrive in the same cycle, the arm wins. The thread sleeps on the newly captured address, and the store is not compared against it.
- R11: After each grant, the rotation pointer moves to the thread after the one granted, wrapping from thread 3 to thread 0, even when threads were skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_set | input | N | Per-thread stall-raise pulses |
| stall_clr | input | N | Per-thread stall-release pulses |
| mwait_req | input | N | Per-thread monitor-arm (sleep) requests |
| mwait_addr | input | N*ADDR_W | Watched address per thread, slice i for thread i |
| st_valid | input | 1 | A store is observed this cycle |
| st_addr | input | ADDR_W | Byte address of the observed store |
| grant_valid | output | 1 | A thread is granted this cycle |
| grant_oh | output | N | One-hot granted thread |
| grant_id | output | $clog2(N) | Index of the granted thread |

## Verification
A corrupted stall or sleep flag shows up at the grant ports one cycle after the event that set it. The thread is then either granted when it should not be, or skipped when its turn in the rotation comes. With four threads, that turn comes within four cycles.

A wrong rotation pointer shows up as a grant order that differs from the expected order on the very next cycle, provided more than one thread is eligible. When no thread is eligible, a pointer that was wrongly changed shows up only in the first grant after recovery. The bench therefore checks that first grant.

A monitor that compares the wrong address bits shows up as a thread that wakes on the wrong store, or never wakes. The bench uses stores in the same line at a different byte offset, and stores to a neighbouring line, to expose both faults.

// File: rtl/tp_pkg.sv
package tp_pkg;
   // Per-context condition flags; eligibility needs both clear.
   typedef struct packed {
      logic stalled;
      logic asleep;
   } ctx_flags_t;

   function automatic logic flags_eligible(input ctx_flags_t f);
      return !(f.stalled || f.asleep);
   endfunction
endpackage

// File: rtl/tp_thread_ctx.sv
module tp_thread_ctx #(
   parameter int LINE_W = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall_set,
   input  logic              stall_clr,
   input  logic              arm,
   input  logic [LINE_W-1:0] arm_line,
   input  logic              st_valid,
   input  logic [LINE_W-1:0] st_line,
   output tp_pkg::ctx_flags_t flags
);
   logic              stalled_q;
   logic              asleep_q;
   logic [LINE_W-1:0] watch_q;
   logic              hit;

   assign hit = st_valid && asleep_q && (st_line == watch_q);

   // Stall tracking: a raise in the same cycle as a release wins.
   always_ff @(posedge clk) begin
      if (!rst_n)          stalled_q <= 1'b0;
      else if (stall_set)  stalled_q <= 1'b1;
      else if (stall_clr)  stalled_q <= 1'b0;
   end

   // Monitor: arming takes priority over a coincident store.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         asleep_q <= 1'b0;
         watch_q  <= '0;
      end else if (arm) begin
         asleep_q <= 1'b1;
         watch_q  <= arm_line;
      end else if (hit) begin
         asleep_q <= 1'b0;
      end
   end

   assign flags.stalled = stalled_q;
   assign flags.asleep  = asleep_q;
endmodule

// File: rtl/tp_rr_pick.sv
module tp_rr_pick #(
   parameter int N   = 4,
   parameter int IDW = $clog2(N)
) (
   input  logic [N-1:0]   eligible,
   input  logic [IDW-1:0] ptr,
   output logic           any,
   output logic [N-1:0]   pick_oh,
   output logic [IDW-1:0] pick_id
);
   generate
      if ((N & (N - 1)) == 0) begin : g_pow2
         // Power-of-two count: index wraps by truncation.
         always_comb begin
            any     = 1'b0;
            pick_oh = '0;
            pick_id = '0;
            for (int k = 0; k < N; k++) begin
               logic [IDW-1:0] idx;
               idx = ptr + IDW'(k);
               if (!any && eligible[idx]) begin
                  any          = 1'b1;
                  pick_id      = idx;
                  pick_oh[idx] = 1'b1;
               end
            end
         end
      end else begin : g_mod
         // Arbitrary count: explicit wrap by subtraction.
         always_comb begin
            any     = 1'b0;
            pick_oh = '0;
            pick_id = '0;
            for (int k = 0; k < N; k++) begin
               int idx;
               idx = int'(ptr) + k;
               if (idx >= N) idx = idx - N;
               if (!any && eligible[idx]) begin
                  any          = 1'b1;
                  pick_id      = IDW'(idx);
                  pick_oh[idx] = 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mt_thread_picker.sv
module mt_thread_picker #(
   parameter int N          = 4,
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   localparam int IDW       = $clog2(N),
   localparam int LINE_LSB  = $clog2(LINE_BYTES),
   localparam int LINE_W    = ADDR_W - LINE_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      stall_set,
   input  logic [N-1:0]      stall_clr,
   input  logic [N-1:0]      mwait_req,
   input  logic [N*ADDR_W-1:0] mwait_addr,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   output logic              grant_valid,
   output logic [N-1:0]      grant_oh,
   output logic [IDW-1:0]    grant_id
);
   generate
      if (N < 2) begin : g_bad_n
         $error("mt_thread_picker: N must be at least 2");
      end
      if ((LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
         $error("mt_thread_picker: LINE_BYTES must be a power of two");
      end
      if (LINE_LSB >= ADDR_W) begin : g_bad_addr
         $error("mt_thread_picker: ADDR_W too small for LINE_BYTES");
      end
   endgenerate

   tp_pkg::ctx_flags_t flags [N];
   logic [N-1:0]       eligible;
   logic [IDW-1:0]     ptr_q;
   logic [LINE_W-1:0]  st_line;

   assign st_line = st_addr[ADDR_W-1:LINE_LSB];

   logic unused_low_bits;
   assign unused_low_bits = ^st_addr[LINE_LSB-1:0];

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_ctx
         logic [ADDR_W-1:0] arm_addr;
         logic              unused_arm_low;
         assign arm_addr       = mwait_addr[gi*ADDR_W +: ADDR_W];
         assign unused_arm_low = ^arm_addr[LINE_LSB-1:0];

         tp_thread_ctx #(.LINE_W(LINE_W)) u_ctx (
            .clk       (clk),
            .rst_n     (rst_n),
            .stall_set (stall_set[gi]),
            .stall_clr (stall_clr[gi]),
            .arm       (mwait_req[gi]),
            .arm_line  (arm_addr[ADDR_W-1:LINE_LSB]),
            .st_valid  (st_valid),
            .st_line   (st_line),
            .flags     (flags[gi])
         );
         assign eligible[gi] = tp_pkg::flags_eligible(flags[gi]);
      end
   endgenerate

   tp_rr_pick #(.N(N), .IDW(IDW)) u_pick (
      .eligible (eligible),
      .ptr      (ptr_q),
      .any      (grant_valid),
      .pick_oh  (grant_oh),
      .pick_id  (grant_id)
   );

   // Rotation pointer: moves past the granted thread, holds when idle.
   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (grant_valid)
         ptr_q <= (grant_id == IDW'(N - 1)) ? '0 : grant_id + 1'b1;
   end
endmodule

// File: rtl/tp_picker_checker.sv
module tp_picker_checker #(
   parameter int N   = 4,
   parameter int IDW = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic [N-1:0]   stall_set,
   input logic [N-1:0]   mwait_req,
   input logic           grant_valid,
   input logic [N-1:0]   grant_oh,
   input logic [IDW-1:0] grant_id
);
   // R1: single grant, valid consistent with the vector, index consistent.
   a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_oh));
   a_r1_valid_vec: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid == (grant_oh != '0));
   a_r1_id_match: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> grant_oh[grant_id]);

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_thr
         // R3: a thread whose stall was just raised is not granted next cycle.
         a_r3_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            stall_set[gi] |=> !grant_oh[gi]);
         // R5: a thread that just armed its monitor is not granted next cycle.
         a_r5_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            mwait_req[gi] |=> !grant_oh[gi]);
      end
   endgenerate
endmodule

bind mt_thread_picker tp_picker_checker #(.N(N), .IDW(IDW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stall_set   (stall_set),
   .mwait_req   (mwait_req),
   .grant_valid (grant_valid),
   .grant_oh    (grant_oh),
   .grant_id    (grant_id)
);

// File: tb/mt_thread_picker_bench.sv
module mt_thread_picker_bench;
   localparam int N  = 4;
   localparam int AW = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    stall_set = '0, stall_clr = '0, mwait_req = '0;
   logic [N*AW-1:0] mwait_addr = '0;
   logic            st_valid = 1'b0;
   logic [AW-1:0]   st_addr = '0;
   logic            grant_valid;
   logic [N-1:0]    grant_oh;
   logic [1:0]      grant_id;

   int checks = 0, errors = 0;

   // Reference state built from the requirements.
   bit            m_stall [N];
   bit            m_sleep [N];
   logic [AW-1:0] m_watch [N];
   int            m_ptr;

   always #5 clk = ~clk;

   mt_thread_picker #(.N(N), .ADDR_W(AW), .LINE_BYTES(64)) u_mt_thread_picker (
      .clk(clk), .rst_n(rst_n), .stall_set(stall_set), .stall_clr(stall_clr),
      .mwait_req(mwait_req), .mwait_addr(mwait_addr), .st_valid(st_valid),
      .st_addr(st_addr), .grant_valid(grant_valid), .grant_oh(grant_oh),
      .grant_id(grant_id));

   function automatic int exp_pick();
      for (int k = 0; k < N; k++) begin
         int idx = (m_ptr + k) % N;
         if (!m_stall[idx] && !m_sleep[idx]) return idx;
      end
      return -1;
   endfunction

   task automatic check_grant(string tag);
      int e = exp_pick();
      logic [N-1:0] eoh = (e < 0) ? '0 : (N'(1) << e);
      checks++;
      if (grant_valid !== (e >= 0) || grant_oh !== eoh ||
          (e >= 0 && grant_id !== 2'(e))) begin
         errors++;
         $display("FAIL %s: valid=%0b oh=%b id=%0d, expected valid=%0b oh=%b id=%0d",
                  tag, grant_valid, grant_oh, grant_id, (e >= 0), eoh, (e < 0) ? 0 : e);
      end
   endtask

   // Check at the current falling edge, drive one cycle of events, update model.
   task automatic tick(string tag, logic [N-1:0] ss = '0, logic [N-1:0] sc = '0,
                       logic [N-1:0] mw = '0, logic [AW-1:0] aa = '0,
                       logic sv = 1'b0, logic [AW-1:0] sa = '0);
      int e;
      check_grant(tag);
      e = exp_pick();
      stall_set = ss; stall_clr = sc; mwait_req = mw;
      for (int i = 0; i < N; i++) mwait_addr[i*AW +: AW] = aa;
      st_valid = sv; st_addr = sa;
      @(posedge clk);
      if (e >= 0) m_ptr = (e + 1) % N;
      for (int i = 0; i < N; i++) begin
         if (ss[i]) m_stall[i] = 1; else if (sc[i]) m_stall[i] = 0;
         if (mw[i]) begin m_sleep[i] = 1; m_watch[i] = aa; end
         else if (sv && m_sleep[i] && sa[AW-1:6] == m_watch[i][AW-1:6]) m_sleep[i] = 0;
      end
      @(negedge clk);
      stall_set = '0; stall_clr = '0; mwait_req = '0; st_valid = 1'b0;
   endtask

   task automatic idle(string tag, int n);
      for (int i = 0; i < n; i++) tick(tag);
   endtask

   task automatic t_reset();
      checks++;
      if (!(grant_valid === 1'b1 && grant_id === 2'd0 && grant_oh === 4'b0001)) begin
         errors++;
         $display("FAIL R9: valid=%0b oh=%b id=%0d, expected valid=1 oh=0001 id=0",
                  grant_valid, grant_oh, grant_id);
      end
      checks++;
      if ($countones(grant_oh) > 1 || grant_valid !== (grant_oh != 0)) begin
         errors++;
         $display("FAIL R1: oh=%b valid=%0b, expected one-hot consistent", grant_oh, grant_valid);
      end
   endtask

   task automatic t_rotate();  idle("R2", 6); idle("R11", 3); endtask

   task automatic t_stall();
      tick("R3", 4'b0010);
      idle("R3", 5);
      tick("R3", '0, 4'b0010);
      idle("R3", 4);
   endtask

   task automatic t_set_wins();
      tick("R4", 4'b0100, 4'b0100);
      idle("R4", 5);
      tick("R4", '0, 4'b0100);
      idle("R4", 2);
   endtask

   task automatic t_sleep();
      tick("R5", '0, '0, 4'b0001, 32'h0000_1000);
      idle("R5", 5);
      tick("R6", '0, '0, '0, '0, 1'b1, 32'h0000_1040);
      idle("R6", 4);
      tick("R6", '0, '0, '0, '0, 1'b1, 32'h0000_103F);
      idle("R6", 4);
      tick("R6", '0, '0, 4'b0101, 32'h0000_8000);
      idle("R6", 3);
      tick("R6", '0, '0, '0, '0, 1'b1, 32'h0000_8010);
      idle("R6", 4);
   endtask

   task automatic t_both();
      tick("R7", 4'b1000, '0, 4'b1000, 32'h0000_4000);
      tick("R7", '0, '0, '0, '0, 1'b1, 32'h0000_4000);
      idle("R7", 5);
      tick("R7", '0, 4'b1000);
      idle("R7", 4);
      tick("R7", 4'b0001, '0, 4'b0001, 32'h0000_5000);
      tick("R7", '0, 4'b0001);
      idle("R7", 5);
      tick("R7", '0, '0, '0, '0, 1'b1, 32'h0000_5020);
      idle("R7", 4);
   endtask

   task automatic t_none();
      tick("R8", 4'b0001);
      tick("R8", 4'b1110);
      idle("R8", 4);
      tick("R8", '0, 4'b1111);
      idle("R8", 5);
   endtask

   task automatic t_arm_vs_store();
      tick("R10", '0, '0, 4'b0010, 32'h0000_A000);
      idle("R10", 2);
      tick("R10", '0, '0, 4'b0010, 32'h0000_B000, 1'b1, 32'h0000_A000);
      idle("R10", 5);
      tick("R10", '0, '0, '0, '0, 1'b1, 32'h0000_A004);
      idle("R10", 4);
      tick("R10", '0, '0, '0, '0, 1'b1, 32'h0000_B004);
      idle("R10", 5);
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_stall[i] = 0; m_sleep[i] = 0; m_watch[i] = '0; end
      m_ptr = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_rotate();
      t_stall();
      t_set_wins();
      t_sleep();
      t_both();
      t_none();
      t_arm_vs_store();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule